// File: doc/BRIEF.md
# Two-Slot PCM Serial Transmitter

This block places two independent audio samples on one serial PCM data line in every frame. Each of the two channels has its own slot. A slot starts a set number of bit clocks after the frame-sync rise, lasts a set number of bits, and launches its bits on the bit clock edge that channel selects. The PCM bit clock comes in as two one-cycle strobes in the system clock domain: one for each rising edge and one for each falling edge. A frame-start strobe arrives together with the rising strobe that marks the sync rise.

Samples arrive as 64-bit parallel words, each with a valid/ready handshake. A channel takes a new word in the tick where its slot begins. The word is left-justified and shifted out most significant bit first. Slots longer than 64 bits continue with zero bits. If no word is waiting when a slot begins, the previous word is sent again and a sticky underrun bit is set for that channel.

The output-enable is high only while a slot is driving the line; outside the slots the line is released. An illegal setting raises a configuration error and silences the transmitter. Illegal settings are a bad slot length or a second slot that starts too early after the first.

Top module: `pcmSlotTx`

## Requirements
- R1: After reset, pcmOe, pcmOut, cfgError and both underrun bits are 0, and no ready is asserted.
- R2: Bit positions are counted in rising bit-clock edges, and position 0 is the rising edge that carries frameStart. Bit k of a channel's slot belongs to position offset+k, for k from 0 to size-1. Offset is 0 to 255 and size is 1 to 640. Bit k is sample[63-k] when k < 64 and 0 otherwise (most significant bit first).
- R3: With chNFallEdge = 0, a bit is launched on the rising tick of its position and holds until the next rising tick. With chNFallEdge = 1, it is launched on the falling tick of its position and holds until the next falling tick.
- R4: pcmOe is 1 exactly while some slot bit is being driven; it is 0 before, between and after the slots.
- R5: A slot length of 1 to 24 is legal. A length of 25 to 640 is legal only if it is a multiple of 8. A length above 640 raises cfgError.
- R6: The channel 2 offset must be at least the channel 1 length plus 1, and this holds even when channel 2's length is 0. Otherwise cfgError is raised.
- R7: cfgError is 1 from the second clock after an illegal setting appears, for as long as the setting remains. While it is 1, pcmOe stays 0 and no ready is asserted.
- R8: chNReady is 1 for one cycle, in the launch tick of the channel's first slot bit, when chNValid is 1. In that case the word on chNSample is the one that gets transmitted.
- R9: If chNValid is 0 in that tick, the previously accepted word is sent again, and underrun bit N-1 (bit 0 for channel 1, bit 1 for channel 2) is set until reset.
- R10: A channel whose length is 0 drives nothing, never asserts ready and never sets its underrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| riseTick | input | 1 | One-cycle strobe per bit-clock rising edge |
| fallTick | input | 1 | One-cycle strobe per bit-clock falling edge |
| frameStart | input | 1 | Frame-sync rise, given together with riseTick |
| ch1Size | input | 10 | Channel 1 slot length in bits (0 = off) |
| ch1Offset | input | 8 | Channel 1 slot start position |
| ch1FallEdge | input | 1 | Channel 1 launch edge (0 rising, 1 falling) |
| ch2Size | input | 10 | Channel 2 slot length in bits (0 = off) |
| ch2Offset | input | 8 | Channel 2 slot start position |
| ch2FallEdge | input | 1 | Channel 2 launch edge |
| ch1Sample | input | 64 | Channel 1 sample word |
| ch1Valid | input | 1 | Channel 1 word available |
| ch1Ready | output | 1 | Channel 1 word taken |
| ch2Sample | input | 64 | Channel 2 sample word |
| ch2Valid | input | 1 | Channel 2 word available |
| ch2Ready | output | 1 | Channel 2 word taken |
| pcmOut | output | 1 | Serial data |
| pcmOe | output | 1 | Output-enable for the data line |
| underrun | output | 2 | Sticky underrun flags, bit 0 channel 1 |
| cfgError | output | 1 | Illegal slot setting |

## Verification
The assertions assume that the tick strobes are one cycle wide and never coincide, and that frameStart comes only together with riseTick. They also assume that slot settings change only while the line is idle. The bench drives the strobes from one frame task on fixed phases of a four-cycle bit period. It changes settings only between frames, with idle cycles in between. It also keeps frames long enough that every slot ends before the next frame-sync.

// File: rtl/pcmTxPkg.sv
`timescale 1ns/1ps
package pcmTxPkg;
  localparam int NUM_CH = 2;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] load;
    logic [NUM_CH-1:0] shift;
    logic [NUM_CH-1:0] stop;
  } txStrobeT;
endpackage

// File: rtl/pcmTxCtrl.sv
`timescale 1ns/1ps
module pcmTxCtrl
  import pcmTxPkg::*;
#(
  parameter int SIZE_W    = 10,
  parameter int OFF_W     = 8,
  parameter int MAX_SIZE  = 640,
  parameter int FREE_SIZE = 24
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           riseTick,
  input  logic                           fallTick,
  input  logic                           frameStart,
  input  logic [NUM_CH-1:0][SIZE_W-1:0]  chSize,
  input  logic [NUM_CH-1:0][OFF_W-1:0]   chOffset,
  input  logic [NUM_CH-1:0]              chFall,
  input  logic [NUM_CH-1:0]              chValid,
  output logic [NUM_CH-1:0]              chReady,
  output logic [NUM_CH-1:0]              underrun,
  output logic                           cfgErr,
  output txStrobeT                       strobe
);
  localparam int POS_W = SIZE_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] posQ, nextPos;
  logic             seenQ, riseOk, fallOk;
  logic             cfgErrQ, cfgBad;
  logic [NUM_CH-1:0] sizeBad, tick, enable, atStart, inWin;
  logic [NUM_CH-1:0][POS_W-1:0] posC, offExt, winEnd;
  logic [NUM_CH-1:0] underrunQ;
  logic             orderBad;

  // bit-position counter, position 0 = rising edge carrying frameStart
  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ  <= '0;
      seenQ <= 1'b0;
    end else if (riseTick) begin
      posQ  <= nextPos;
      if (frameStart) seenQ <= 1'b1;
    end
  end

  assign nextPos = frameStart ? '0 : ((posQ == POS_MAX) ? posQ : posQ + 1'b1);
  assign riseOk  = riseTick && (frameStart || seenQ);
  assign fallOk  = fallTick && seenQ;

  // configuration legality
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      sizeBad[c] = (chSize[c] > SIZE_W'(MAX_SIZE)) ||
                   ((chSize[c] > SIZE_W'(FREE_SIZE)) && (chSize[c][2:0] != 3'd0));
    end
    orderBad = POS_W'(chOffset[1]) < (POS_W'(chSize[0]) + POS_W'(1));
    cfgBad   = (|sizeBad) || orderBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgErrQ <= 1'b0;
    else       cfgErrQ <= cfgBad;
  end
  assign cfgErr = cfgErrQ;

  // slot window decode per channel
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      tick[c]    = chFall[c] ? fallOk : riseOk;
      posC[c]    = chFall[c] ? posQ : nextPos;
      offExt[c]  = POS_W'(chOffset[c]);
      winEnd[c]  = offExt[c] + POS_W'(chSize[c]);
      enable[c]  = (chSize[c] != '0) && !cfgErrQ;
      atStart[c] = tick[c] && enable[c] && (posC[c] == offExt[c]);
      inWin[c]   = (posC[c] > offExt[c]) && (posC[c] < winEnd[c]);
      strobe.load[c]  = atStart[c];
      strobe.shift[c] = tick[c] && enable[c] && !atStart[c] && inWin[c];
      strobe.stop[c]  = tick[c] && !atStart[c] && !(enable[c] && inWin[c]);
      chReady[c]      = atStart[c] && chValid[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) underrunQ <= '0;
    else begin
      for (int c = 0; c < NUM_CH; c++)
        if (atStart[c] && !chValid[c]) underrunQ[c] <= 1'b1;
    end
  end
  assign underrun = underrunQ;

  AST_ORDER_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgErrQ && $stable(chOffset[1]) && $stable(chSize[0])) |->
      (POS_W'(chOffset[1]) > POS_W'(chSize[0]))) else $error("order");   // R6

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    AST_SIZE_RULE: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgErrQ && $stable(chSize[g])) |->
        ((chSize[g] <= SIZE_W'(FREE_SIZE)) ||
         ((chSize[g] <= SIZE_W'(MAX_SIZE)) && (chSize[g][2:0] == 3'd0))))
      else $error("size");   // R5
    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(underrunQ[g]) |-> $past(strobe.load[g] && !chValid[g]))
      else $error("underrun");   // R9
  end
endmodule

// File: rtl/pcmTxPath.sv
`timescale 1ns/1ps
module pcmTxPath
  import pcmTxPkg::*;
#(
  parameter int SAMPLE_W = 64
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  txStrobeT                         strobe,
  input  logic                             cfgErr,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  chSample,
  input  logic [NUM_CH-1:0]                chValid,
  output logic                             pcmOut,
  output logic                             pcmOe
);
  logic [NUM_CH-1:0][SAMPLE_W-1:0] heldQ, shQ;
  logic [NUM_CH-1:0]               actQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ <= '0;
      shQ   <= '0;
      actQ  <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfgErr) begin
          actQ[c] <= 1'b0;
        end else if (strobe.load[c]) begin
          actQ[c] <= 1'b1;
          shQ[c]  <= chValid[c] ? chSample[c] : heldQ[c];
          if (chValid[c]) heldQ[c] <= chSample[c];
        end else if (strobe.shift[c]) begin
          shQ[c]  <= {shQ[c][SAMPLE_W-2:0], 1'b0};
        end else if (strobe.stop[c]) begin
          actQ[c] <= 1'b0;
        end
      end
    end
  end

  // lower channel number wins the line
  always_comb begin
    pcmOut = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (actQ[c]) pcmOut = shQ[c][SAMPLE_W-1];
  end
  assign pcmOe = |actQ;

  AST_ERR_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> !pcmOe) else $error("err");   // R7

  for (genvar g = 0; g < NUM_CH; g++) begin : gAct
    AST_SLOT_BY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      $rose(actQ[g]) |-> $past(strobe.load[g])) else $error("load");   // R2
  end
endmodule

// File: rtl/pcmSlotTx.sv
`timescale 1ns/1ps
module pcmSlotTx
  import pcmTxPkg::*;
#(
  parameter int SAMPLE_W = 64,
  parameter int SIZE_W   = 10,
  parameter int OFF_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                riseTick,
  input  logic                fallTick,
  input  logic                frameStart,
  input  logic [SIZE_W-1:0]   ch1Size,
  input  logic [OFF_W-1:0]    ch1Offset,
  input  logic                ch1FallEdge,
  input  logic [SIZE_W-1:0]   ch2Size,
  input  logic [OFF_W-1:0]    ch2Offset,
  input  logic                ch2FallEdge,
  input  logic [SAMPLE_W-1:0] ch1Sample,
  input  logic                ch1Valid,
  output logic                ch1Ready,
  input  logic [SAMPLE_W-1:0] ch2Sample,
  input  logic                ch2Valid,
  output logic                ch2Ready,
  output logic                pcmOut,
  output logic                pcmOe,
  output logic [NUM_CH-1:0]   underrun,
  output logic                cfgError
);
  txStrobeT                        strobe;
  logic [NUM_CH-1:0]               readyVec;
  logic [NUM_CH-1:0]               validVec;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] sampleVec;

  assign validVec  = {ch2Valid, ch1Valid};
  assign sampleVec = {ch2Sample, ch1Sample};
  assign ch1Ready  = readyVec[0];
  assign ch2Ready  = readyVec[1];

  pcmTxCtrl #(.SIZE_W(SIZE_W), .OFF_W(OFF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .riseTick(riseTick), .fallTick(fallTick),
    .frameStart(frameStart),
    .chSize({ch2Size, ch1Size}), .chOffset({ch2Offset, ch1Offset}),
    .chFall({ch2FallEdge, ch1FallEdge}), .chValid(validVec),
    .chReady(readyVec), .underrun(underrun), .cfgErr(cfgError),
    .strobe(strobe)
  );

  pcmTxPath #(.SAMPLE_W(SAMPLE_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgErr(cfgError),
    .chSample(sampleVec), .chValid(validVec),
    .pcmOut(pcmOut), .pcmOe(pcmOe)
  );
endmodule

// File: tb/sim_pcmSlotTx.sv
`timescale 1ns/1ps
module sim_pcmSlotTx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic riseTick = 0, fallTick = 0, frameStart = 0;
  logic [9:0] ch1Size = 10'd8, ch2Size = 10'd0;
  logic [7:0] ch1Offset = 0, ch2Offset = 8'd20;
  logic ch1FallEdge = 0, ch2FallEdge = 0;
  logic [63:0] ch1Sample = 0, ch2Sample = 0;
  logic ch1Valid = 0, ch2Valid = 0;
  logic ch1Ready, ch2Ready, pcmOut, pcmOe, cfgError;
  logic [1:0] underrun;

  int checks = 0, fails = 0;
  int rdy1, rdy2, errOe;
  bit done = 0;
  bit capRO[0:1100], capRD[0:1100], capFO[0:1100], capFD[0:1100];
  bit expRO[0:1100], expRD[0:1100], expFO[0:1100], expFD[0:1100];

  always #2.5 clk = ~clk;

  pcmSlotTx u0 (
    .clk(clk), .rstN(rstN), .riseTick(riseTick), .fallTick(fallTick),
    .frameStart(frameStart),
    .ch1Size(ch1Size), .ch1Offset(ch1Offset), .ch1FallEdge(ch1FallEdge),
    .ch2Size(ch2Size), .ch2Offset(ch2Offset), .ch2FallEdge(ch2FallEdge),
    .ch1Sample(ch1Sample), .ch1Valid(ch1Valid), .ch1Ready(ch1Ready),
    .ch2Sample(ch2Sample), .ch2Valid(ch2Valid), .ch2Ready(ch2Ready),
    .pcmOut(pcmOut), .pcmOe(pcmOe), .underrun(underrun), .cfgError(cfgError)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic setCfg(int s1, int o1, bit f1, int s2, int o2, bit f2);
    @(negedge clk);
    ch1Size = 10'(s1); ch1Offset = 8'(o1); ch1FallEdge = f1;
    ch2Size = 10'(s2); ch2Offset = 8'(o2); ch2FallEdge = f2;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearExp();
    for (int p = 0; p <= 1100; p++) begin
      expRO[p] = 0; expRD[p] = 0; expFO[p] = 0; expFD[p] = 0;
    end
  endtask

  task automatic addSlot(int off, int size, bit fallE, logic [63:0] w);
    for (int k = 0; k < size; k++) begin
      bit b = (k < 64) ? w[63-k] : 1'b0;
      int p = off + k;
      if (!fallE) begin
        expRO[p] = 1; expRD[p] = b; expFO[p] = 1; expFD[p] = b;
      end else begin
        expFO[p] = 1; expFD[p] = b; expRO[p+1] = 1; expRD[p+1] = b;
      end
    end
  endtask

  task automatic runFrame(int nBits);
    rdy1 = 0; rdy2 = 0; errOe = 0;
    for (int p = 0; p <= 1100; p++) begin
      capRO[p] = 0; capRD[p] = 0; capFO[p] = 0; capFD[p] = 0;
    end
    for (int p = 0; p < nBits; p++) begin
      @(negedge clk); riseTick = 1; frameStart = (p == 0); #1;
      if (ch1Ready) rdy1++;
      if (ch2Ready) rdy2++;
      @(negedge clk); riseTick = 0; frameStart = 0;
      capRO[p] = pcmOe; capRD[p] = pcmOut;
      @(negedge clk); fallTick = 1; #1;
      if (ch1Ready) rdy1++;
      if (ch2Ready) rdy2++;
      @(negedge clk); fallTick = 0;
      capFO[p] = pcmOe; capFD[p] = pcmOut;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic compareFrame(string req, int nBits);
    int bad = -1;
    bit aO = 0, eO = 0, aD = 0, eD = 0;
    for (int p = nBits - 1; p >= 0; p--) begin
      if (capRO[p] != expRO[p] || (expRO[p] && capRD[p] != expRD[p])) begin
        bad = 2 * p; aO = capRO[p]; eO = expRO[p]; aD = capRD[p]; eD = expRD[p];
      end
      if (capFO[p] != expFO[p] || (expFO[p] && capFD[p] != expFD[p])) begin
        bad = 2 * p + 1; aO = capFO[p]; eO = expFO[p]; aD = capFD[p]; eD = expFD[p];
      end
    end
    check(bad < 0, req, $sformatf("line half %0d oe/data", bad),
          {aO, aD}, {eO, eD});
  endtask

  task automatic testReset();
    check(pcmOe == 0 && pcmOut == 0, "R1", "oe/data after reset", {pcmOe, pcmOut}, 0);
    check(cfgError == 0 && underrun == 0, "R1", "flags after reset", {cfgError, underrun}, 0);
    check(ch1Ready == 0 && ch2Ready == 0, "R1", "ready after reset", {ch1Ready, ch2Ready}, 0);
  endtask

  task automatic testBasic();
    setCfg(8, 0, 0, 16, 10, 1);
    ch1Sample = 64'hA5C3_0000_0000_0000; ch2Sample = 64'h9E71_0000_0000_0000;
    ch1Valid = 1; ch2Valid = 1;
    clearExp(); addSlot(0, 8, 0, ch1Sample); addSlot(10, 16, 1, ch2Sample);
    runFrame(30);
    compareFrame("R2 R3 R4 basic", 30);
    check(rdy1 == 1 && rdy2 == 1, "R8", "ready pulses", {rdy1, rdy2}, {32'd1, 32'd1});
    check(underrun == 0, "R9", "no underrun with valid", underrun, 0);
  endtask

  task automatic testLong();
    setCfg(96, 3, 1, 40, 120, 0);
    check(cfgError == 0, "R5", "sizes 96 and 40 legal", cfgError, 0);
    ch1Sample = 64'hF00D_1234_5678_9ABC; ch2Sample = 64'h8421_0FED_CBA9_8765;
    clearExp(); addSlot(3, 96, 1, ch1Sample); addSlot(120, 40, 0, ch2Sample);
    runFrame(165);
    compareFrame("R2 R3 long slots zero-padded", 165);
  endtask

  task automatic testUnderrun();
    setCfg(8, 0, 0, 16, 10, 1);
    ch1Sample = 64'h3C00_0000_0000_0000; ch2Sample = 64'h5AF0_0000_0000_0000;
    ch1Valid = 1; ch2Valid = 1;
    runFrame(30);
    ch1Valid = 0; ch2Valid = 0;
    ch1Sample = 64'hFFFF_FFFF_FFFF_FFFF; ch2Sample = 64'hFFFF_FFFF_FFFF_FFFF;
    clearExp(); addSlot(0, 8, 0, 64'h3C00_0000_0000_0000);
    addSlot(10, 16, 1, 64'h5AF0_0000_0000_0000);
    runFrame(30);
    compareFrame("R9 repeat previous", 30);
    check(underrun == 2'b11, "R9", "underrun flags", underrun, 3);
    check(rdy1 == 0 && rdy2 == 0, "R8", "no ready without valid", {rdy1, rdy2}, 0);
    doReset();
    check(underrun == 0, "R1", "underrun cleared by reset", underrun, 0);
  endtask

  task automatic testEdges();
    setCfg(1, 255, 0, 24, 2, 1);
    check(cfgError == 0, "R5", "size 24 legal", cfgError, 0);
    ch1Sample = 64'h8000_0000_0000_0000; ch2Sample = 64'hC0FFEE00_0000_0000;
    ch1Valid = 1; ch2Valid = 1;
    clearExp(); addSlot(255, 1, 0, ch1Sample); addSlot(2, 24, 1, ch2Sample);
    runFrame(260);
    compareFrame("R2 R4 offset 255 size 1", 260);
  endtask

  task automatic testDisabled();
    setCfg(0, 0, 0, 12, 1, 0);
    check(cfgError == 0, "R10", "size 0 not an error", cfgError, 0);
    ch1Valid = 0; ch2Valid = 1;
    ch2Sample = 64'hB6D0_0000_0000_0000;
    clearExp(); addSlot(1, 12, 0, ch2Sample);
    runFrame(20);
    compareFrame("R10 disabled channel silent", 20);
    check(underrun[0] == 0, "R10", "no underrun on disabled", underrun, 0);
    ch1Valid = 1;
    runFrame(20);
    check(rdy1 == 0, "R10", "no ready on disabled", rdy1, 0);
  endtask

  task automatic testErrors();
    setCfg(25, 0, 0, 0, 30, 0);
    check(cfgError == 1, "R5", "size 25 rejected", cfgError, 1);
    setCfg(32, 0, 0, 641, 40, 0);
    check(cfgError == 1, "R5", "size 641 rejected", cfgError, 1);
    setCfg(32, 0, 0, 0, 33, 0);
    check(cfgError == 0, "R6", "offset size+1 accepted", cfgError, 0);
    setCfg(8, 0, 0, 0, 8, 0);
    check(cfgError == 1, "R6", "offset too small, ch2 off", cfgError, 1);
    ch1Valid = 1; ch2Valid = 1;
    clearExp();
    runFrame(20);
    compareFrame("R7 line silent on error", 20);
    check(rdy1 == 0 && rdy2 == 0, "R7", "no ready on error", {rdy1, rdy2}, 0);
    setCfg(8, 0, 0, 0, 9, 0);
    check(cfgError == 0, "R7", "error clears with legal setting", cfgError, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    testReset();
    testBasic();
    testLong();
    testUnderrun();
    testEdges();
    testDisabled();
    testErrors();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule